// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block connects a synchronous request port to an asynchronous static RAM that is one byte wide. A client offers a request with a valid/ready handshake: a 21-bit word address, a write flag and one byte of write data. The controller then drives the memory's active-low chip select, write enable and output enable strobes, the address bus and a tristate data bus, which is split into a driven value, a drive enable and an input. Read data goes back to the client with a one-cycle valid strobe.

Every timing limit of the memory is a parameter in nanoseconds. The controller converts each limit to whole clock cycles by rounding up against a clock-period parameter, and it never uses a count below one. Write strobes are timed on write enable. A write has three phases: a setup cycle in which address and data are presented, a low pulse on write enable, and a recovery gap. The recovery gap is stretched when needed so that the whole write meets the minimum write cycle time. A read holds output enable low for the access time and captures the data on its final wait cycle. After a read, chip select stays low, so a following read starts its access simply by changing the address.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after synchronous reset, `req_ready` is 1, `rd_valid` is 0, all three memory strobes are high and `mem_dq_oe` is 0.
- R2: Write enable is low only while chip select is low, output enable is high and the data bus is driven. The low pulse lasts at least the larger of the pulse-width limit (7 ns) and the data-setup limit (6 ns), rounded up to whole cycles. Data is driven throughout the pulse, so write data is stable at least 6 ns before write enable rises.
- R3: The address is stable from before write enable falls until after it rises, and it has been stable for at least 10 ns when write enable rises.
- R4: Between two write pulses, write enable stays high for at least 5 ns. From setup through gap, each write takes at least the 12 ns write cycle time.
- R5: A read holds chip select and output enable low and write enable high for ceil(20 ns / clock period) cycles (4 at 5 ns). It samples `mem_dq_in` at the end of the last of those cycles, and the sampled byte appears on `rd_data`.
- R6: `rd_valid` is high for exactly one cycle. That cycle starts at the clock edge that comes ceil(20 ns / period) edges after the edge that accepted the read.
- R7: The controller never drives the data bus while output enable is low, and `mem_dq_oe` is low in the cycle before output enable falls.
- R8: `req_ready` is low for every cycle of an access in progress. A read and a write each take 4 busy cycles at the default parameters.
- R9: When a read completes, chip select stays low in the idle cycle that follows, so back-to-back reads never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_addr | input | 21 | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 8 | Read result |
| mem_addr | output | 21 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Value driven on the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
Call the accepting clock edge E. A read's result is due in the cycle after edge E+4, and the read's expected byte and that cycle number are pushed into a scoreboard when the request is accepted. The monitor samples on the falling clock edge and requires that each `rd_valid` falls exactly on its due cycle with the right byte. Busy cycles of `req_ready` are checked on the four falling edges after acceptance. The memory model measures write pulse width, write gap, data setup and address setup in absolute time at each write-enable edge. It returns a junk byte until its access time has elapsed after the latest address or strobe change, so a controller that samples too early reads the wrong value.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// asram_pkg: shared state encoding and nanosecond-to-cycle helpers for the
// asynchronous SRAM controller. Assumes all limits are non-negative integers.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WGAP   = 3'd3,
        ST_RWAIT  = 3'd4
    } seq_state_t;

    // Ceiling division of a limit by the clock period, never below one cycle.
    function automatic int ns_to_cyc(input int limit_ns, input int period_ns);
        int c;
        c = (limit_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wait_timer.sv
`timescale 1ns/1ps
// asram_wait_timer: loadable down counter that marks the final cycle of a
// timed phase. Assumes load_val >= 1; 'last' is high while the count is 1.
module asram_wait_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    // Load a new phase length or count the current phase down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CW'(1));

endmodule

// File: rtl/asram_seq_fsm.sv
`timescale 1ns/1ps
// asram_seq_fsm: sequences the phases of one access (write setup, write pulse,
// write gap, or read wait) with phase lengths given in cycles. Assumes every
// length is at least one; accepts a new request only in idle.
module asram_seq_fsm
    import asram_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int GAP_CYC   = 1,
    parameter int READ_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_we,
    output logic       req_ready,
    output logic       accept,
    output logic       rd_sample,
    output seq_state_t state
);
    localparam int MAXC = max_of(max_of(SETUP_CYC, PULSE_CYC), max_of(GAP_CYC, READ_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state_nx;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_last;

    asram_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_sample = (state == ST_RWAIT) && t_last;

    // Next phase and the length to load when a phase ends.
    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        case (state)
            ST_IDLE: if (req_valid) begin
                t_load = 1'b1;
                if (req_we) begin
                    state_nx = ST_WSETUP;
                    t_val    = CW'(SETUP_CYC);
                end else begin
                    state_nx = ST_RWAIT;
                    t_val    = CW'(READ_CYC);
                end
            end
            ST_WSETUP: if (t_last) begin
                state_nx = ST_WPULSE;
                t_load   = 1'b1;
                t_val    = CW'(PULSE_CYC);
            end
            ST_WPULSE: if (t_last) begin
                state_nx = ST_WGAP;
                t_load   = 1'b1;
                t_val    = CW'(GAP_CYC);
            end
            ST_WGAP:  if (t_last) state_nx = ST_IDLE;
            ST_RWAIT: if (t_last) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    assert_pulse_follows_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WPULSE && $past(state) != ST_WPULSE) |-> $past(state) == ST_WSETUP);

endmodule

// File: rtl/asram_pin_drive.sv
`timescale 1ns/1ps
// asram_pin_drive: holds the accepted address and write byte, decodes the
// memory strobes and bus drive from the phase, and captures read data.
// Assumes the phase input comes from a register (strobes are glitch-free decodes).
module asram_pin_drive
    import asram_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic              rd_sample,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic cs_hold;

    // Latch address and write byte when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Keep chip select low after a read; drop the hold when a write is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cs_hold <= 1'b0;
        else if (rd_sample)         cs_hold <= 1'b1;
        else if (accept && req_we)  cs_hold <= 1'b0;
    end

    // Capture the read byte on the final wait cycle and strobe it once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_sample;
            if (rd_sample) rd_data <= mem_dq_in;
        end
    end

    // Strobe and bus-drive decode from the current phase.
    always_comb begin
        mem_cs_n  = (state == ST_IDLE) ? !cs_hold : 1'b0;
        mem_we_n  = (state != ST_WPULSE);
        mem_oe_n  = (state != ST_RWAIT);
        mem_dq_oe = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WGAP);
    end

    assert_no_drive_under_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    assert_release_before_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    assert_we_with_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

    assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> $stable(mem_addr));

    assert_rvalid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_cs_held_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !mem_cs_n);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// asram_ctrl: synchronous request port to asynchronous byte-wide SRAM.
// Converts nanosecond limits to cycle counts (ceiling, minimum one) and
// stretches the write gap so one write meets the write cycle time.
// Assumes a single outstanding request and a clock period in whole ns.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_ACCESS_NS   = 20,
    parameter int T_WPULSE_NS   = 7,
    parameter int T_DSETUP_NS   = 6,
    parameter int T_AWRITE_NS   = 10,
    parameter int T_WGAP_NS     = 5,
    parameter int T_WCYCLE_NS   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int SETUP_CYC = 1;
    localparam int PULSE_CYC = max_of(max_of(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS)),
                                      ns_to_cyc(T_AWRITE_NS, CLK_PERIOD_NS));
    localparam int WCYC      = ns_to_cyc(T_WCYCLE_NS, CLK_PERIOD_NS);
    localparam int GAP_CYC   = max_of(ns_to_cyc(T_WGAP_NS, CLK_PERIOD_NS),
                                      WCYC - SETUP_CYC - PULSE_CYC);
    localparam int READ_CYC  = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);

    seq_state_t state;
    logic       accept;
    logic       rd_sample;

    asram_seq_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .GAP_CYC   (GAP_CYC),
        .READ_CYC  (READ_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_ready (req_ready),
        .accept    (accept),
        .rd_sample (rd_sample),
        .state     (state)
    );

    asram_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .accept     (accept),
        .rd_sample  (rd_sample),
        .req_addr   (req_addr),
        .req_we     (req_we),
        .req_wdata  (req_wdata),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assert_ready_idle_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid));

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench with a timed behavioural SRAM model.
module asram_ctrl_tb;
    localparam int  AW       = 21;
    localparam int  DW       = 8;
    localparam real HALF     = 2.5;
    localparam real MODEL_ACC = 18.0;   // model access time, inside the 20 ns limit
    localparam int  RD_LAT   = 4;       // ceil(20/5)
    localparam int  BUSY     = 4;       // read 4; write 1 + 2 + 1

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_we = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(HALF) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] mem_arr [logic [AW-1:0]];
    realtime t_we_fall = 0, t_we_rise = -1.0, t_data_chg = 0, t_addr_chg = 0;
    int gen = 0;

    always @(mem_dq_out or mem_dq_oe) t_data_chg = $realtime;
    always @(mem_addr) begin
        t_addr_chg = $realtime;
        if (rst_n && !mem_we_n) check(0, "R3 addr moved during write pulse", 1, 0);
    end

    always @(negedge mem_we_n) if (rst_n) begin
        t_we_fall = $realtime;
        if (t_we_rise >= 0)   // R4 gap since previous write pulse
            check(($realtime - t_we_rise) >= 5.0, "R4 write gap ns", longint'($realtime - t_we_rise), 5);
    end

    always @(posedge mem_we_n) if (rst_n) begin
        t_we_rise = $realtime;
        check(($realtime - t_we_fall) >= 7.0, "R2 write pulse ns", longint'($realtime - t_we_fall), 7);
        check(($realtime - t_data_chg) >= 6.0 && mem_dq_oe, "R2 data setup ns",
              longint'($realtime - t_data_chg), 6);
        check(($realtime - t_addr_chg) >= 10.0, "R3 addr to end of write ns",
              longint'($realtime - t_addr_chg), 10);
        if (!mem_cs_n) mem_arr[mem_addr] = mem_dq_out;
    end

    // Read path: junk until the access time after the latest change.
    always @(mem_addr or mem_cs_n or mem_oe_n or mem_we_n) begin
        gen++;
        mem_dq_in = 8'hEE;
        fork
            begin
                automatic int g = gen;
                #(MODEL_ACC);
                if (g == gen && !mem_cs_n && !mem_oe_n && mem_we_n)
                    mem_dq_in = mem_arr.exists(mem_addr) ? mem_arr[mem_addr] : 8'h00;
            end
        join_none
    end

    // ---------------- scoreboard ----------------
    typedef struct { logic [DW-1:0] data; int due; } exp_t;
    exp_t exp_q[$];
    logic [DW-1:0] shadow [logic [AW-1:0]];

    // Monitor: compare read results and watch bus ownership.
    always @(negedge clk) if (rst_n) begin
        if (!mem_oe_n) check(!mem_dq_oe, "R7 bus driven under oe", mem_dq_oe, 0);
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected rd_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_data == e.data, "R5 read data", rd_data, e.data);
                check(cyc == e.due, "R6 read latency cycle", cyc, e.due);
                check(!mem_cs_n, "R9 cs held after read", mem_cs_n, 0);
            end
        end
    end

    // Driver: issue one request, push the expected result, check busy cycles.
    task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int acc;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        if (we) shadow[a] = d;
        else begin
            exp_t e;
            e.data = shadow.exists(a) ? shadow[a] : 8'h00;
            e.due  = acc + RD_LAT;
            exp_q.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R8 busy cycle", req_ready, 0);
        for (int k = 1; k < BUSY; k++) begin
            @(negedge clk);
            check(!req_ready, "R8 busy cycle", req_ready, 0);
            if (!we && k == 2)   // R5 strobes during read wait
                check(!mem_cs_n && !mem_oe_n && mem_we_n, "R5 read strobes",
                      {mem_cs_n, mem_oe_n, mem_we_n}, 3'b001);
        end
    endtask

    task automatic chk_reset_state(input string when);
        check(req_ready == 1'b1, {"R1 ready ", when}, req_ready, 1);
        check(rd_valid == 1'b0, {"R1 rd_valid ", when}, rd_valid, 0);
        check({mem_cs_n, mem_we_n, mem_oe_n} == 3'b111, {"R1 strobes ", when},
              {mem_cs_n, mem_we_n, mem_oe_n}, 7);
        check(mem_dq_oe == 1'b0, {"R1 bus drive ", when}, mem_dq_oe, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_reset_state("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("after reset");

        do_req(1, 21'h000001, 8'h5A);    // back-to-back writes (R2 R3 R4)
        do_req(1, 21'h1FFFFF, 8'hA5);
        do_req(1, 21'h000000, 8'h3C);
        do_req(0, 21'h000001, 8'h00);    // back-to-back reads (R5 R6 R9)
        do_req(0, 21'h1FFFFF, 8'h00);
        do_req(0, 21'h000000, 8'h00);
        do_req(1, 21'h0ABCDE, 8'hFF);    // read then write then read (R7)
        do_req(0, 21'h0ABCDE, 8'h00);
        do_req(1, 21'h0ABCDE, 8'h01);    // overwrite
        do_req(0, 21'h0ABCDE, 8'h00);
        do_req(0, 21'h155555, 8'h00);    // never written: model returns 0
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule